// File: doc/BRIEF.md
# Split-Transaction Bus Arbiter

This block arbitrates a shared system bus whose address bus and data bus are granted separately. Each master raises a request line for the address bus. The arbiter picks one requester in round-robin order and grants the address bus to it. It closes that address tenure with a one-cycle acknowledge pulse, and at the same moment it records the master's index in an ordered queue of transfers that still owe their data.

The data bus side works on its own. Whenever the data bus is free and the queue is not empty, the master at the head of the queue receives the data bus grant. It keeps the grant until it flags its final data beat. Because the two sides are decoupled, new address tenures from the same master or from other masters can run while earlier data tenures are still in flight. The queue depth sets the pipelining limit. Once the queue is full, acknowledges are held back until a data tenure retires.

All pins are plain level controls. There is no streaming payload, so no valid/ready handshake is used and no back-pressure exists beyond the withheld acknowledge.

Top module: `split_bus_arbiter`

## Requirements
- R1: At most one bit of `abus_gnt` is high in any cycle, and at most one bit of `dbus_gnt` is high in any cycle.
- R2: Address requesters are served in round-robin order. The search starts at the master after the last one granted, wrapping from N_MASTERS-1 to 0, and it starts at master 0 after reset.
- R3: An address grant is issued only from the idle state, on the clock edge that samples the request. A request made while the address bus is granted or acknowledging has no effect. A grant stays unchanged until its acknowledge has been given.
- R4: When the queue has room, `abus_ack` goes high for exactly one cycle, starting one cycle after the grant appears. The grant drops on the edge that ends the acknowledge, and the address side is idle for one cycle before it can grant again.
- R5: The acknowledge is withheld for as long as the queue holds PIPE_DEPTH entries. The grant stays high while the acknowledge is withheld.
- R6: Data grants go to masters in the order their addresses were acknowledged. A data grant is issued on the edge after the data bus becomes idle, provided the queue is not empty.
- R7: A data grant is held until `dbus_last` is high at the granted master's bit. A `dbus_last` bit from any other master has no effect.
- R8: The data grant drops on the edge that samples the final beat. That edge removes the head entry, and the next head may be granted on the following edge.
- R9: A synchronous reset, sampled on a rising edge, clears every grant and the acknowledge, empties the queue and resets the round-robin pointer.
- R10: Address grants and acknowledges continue while a data grant is outstanding, up to the depth limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| abus_req | input | N_MASTERS | Per-master address bus request |
| abus_gnt | output | N_MASTERS | One-hot address bus grant |
| abus_ack | output | 1 | One-cycle address acknowledge pulse |
| dbus_gnt | output | N_MASTERS | One-hot data bus grant |
| dbus_last | input | N_MASTERS | Per-master final data beat flag |

## Verification
All outputs are registered. A request seen on a rising edge shows up as a grant right after that edge. The acknowledge follows one edge later, and the grant clears one edge after that. A pushed entry can produce a data grant on the edge after the acknowledge edge, and a final beat clears the data grant on the edge that samples it. The bench drives inputs at the falling edge and compares all three outputs just after the next rising edge. Its vector table was worked out edge by edge from these latencies, including the case where a full queue stalls the acknowledge.

// File: rtl/split_arb_pkg.sv
package split_arb_pkg;
  typedef enum logic [1:0] {
    APH_IDLE  = 2'd0,
    APH_GRANT = 2'd1,
    APH_ACK   = 2'd2
  } aphase_e;
endpackage

// File: rtl/split_arb_rr_pick.sv
module split_arb_rr_pick #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] start,
  output logic           found,
  output logic [IDW-1:0] win
);
  int unsigned idx_v;

  // scan N positions beginning at start, wrapping at N
  always_comb begin
    found = 1'b0;
    win   = '0;
    idx_v = 0;
    for (int i = 0; i < N; i++) begin
      idx_v = int'(start) + i;
      if (idx_v >= N) idx_v = idx_v - N;
      if (!found && req[idx_v]) begin
        found = 1'b1;
        win   = IDW'(idx_v);
      end
    end
  end
endmodule

// File: rtl/split_arb_id_fifo.sv
module split_arb_id_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_id,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] fill_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push) begin
        slots[wr_q] <= push_id;
        wr_q        <= bump(wr_q);
      end
      if (pop) rd_q <= bump(rd_q);
      if (push && !pop)      fill_q <= fill_q + 1'b1;
      else if (pop && !push) fill_q <= fill_q - 1'b1;
    end
  end

  assign head  = slots[rd_q];
  assign empty = (fill_q == '0);
  assign full  = (fill_q == CW'(DEPTH));
endmodule

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter #(
  parameter int N_MASTERS  = 4,
  parameter int PIPE_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] abus_req,
  output logic [N_MASTERS-1:0] abus_gnt,
  output logic                 abus_ack,
  output logic [N_MASTERS-1:0] dbus_gnt,
  input  logic [N_MASTERS-1:0] dbus_last
);
  import split_arb_pkg::*;

  localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
  localparam logic [N_MASTERS-1:0] ONE = N_MASTERS'(1);

  aphase_e        aph_q;
  logic [IDW-1:0] rr_ptr_q, owner_q;
  logic           pick_found;
  logic [IDW-1:0] pick_win;
  logic           q_push, q_pop, q_empty, q_full;
  logic [IDW-1:0] q_head;
  logic           dbusy_q;

  split_arb_rr_pick #(.N(N_MASTERS), .IDW(IDW)) u_pick (
    .req   (abus_req),
    .start (rr_ptr_q),
    .found (pick_found),
    .win   (pick_win)
  );

  split_arb_id_fifo #(.DEPTH(PIPE_DEPTH), .W(IDW)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .push    (q_push),
    .push_id (owner_q),
    .pop     (q_pop),
    .head    (q_head),
    .empty   (q_empty),
    .full    (q_full)
  );

  // the acknowledge and the queue push happen on the same edge
  assign q_push = (aph_q == APH_GRANT) && !q_full;
  // the final beat counts only from the granted master
  assign q_pop  = dbusy_q && |(dbus_gnt & dbus_last);

  // address side
  always_ff @(posedge clk) begin
    if (rst) begin
      aph_q    <= APH_IDLE;
      abus_gnt <= '0;
      abus_ack <= 1'b0;
      rr_ptr_q <= '0;
      owner_q  <= '0;
    end else begin
      unique case (aph_q)
        APH_IDLE: if (pick_found) begin
          abus_gnt <= ONE << pick_win;
          owner_q  <= pick_win;
          rr_ptr_q <= (pick_win == IDW'(N_MASTERS - 1)) ? '0 : pick_win + 1'b1;
          aph_q    <= APH_GRANT;
        end
        APH_GRANT: if (!q_full) begin
          abus_ack <= 1'b1;
          aph_q    <= APH_ACK;
        end
        APH_ACK: begin
          abus_ack <= 1'b0;
          abus_gnt <= '0;
          aph_q    <= APH_IDLE;
        end
        default: aph_q <= APH_IDLE;
      endcase
    end
  end

  // data side
  always_ff @(posedge clk) begin
    if (rst) begin
      dbusy_q  <= 1'b0;
      dbus_gnt <= '0;
    end else if (dbusy_q) begin
      if (q_pop) begin
        dbusy_q  <= 1'b0;
        dbus_gnt <= '0;
      end
    end else if (!q_empty) begin
      dbusy_q  <= 1'b1;
      dbus_gnt <= ONE << q_head;
    end
  end
endmodule

// File: rtl/split_arb_chk.sv
module split_arb_chk #(
  parameter int N     = 4,
  parameter int DEPTH = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] abus_req,
  input logic [N-1:0] abus_gnt,
  input logic         abus_ack,
  input logic [N-1:0] dbus_gnt,
  input logic [N-1:0] dbus_last
);
  localparam int CW = $clog2(DEPTH + 2);

  logic [CW-1:0] outstanding_q;
  logic          retire;

  assign retire = |(dbus_gnt & dbus_last);

  // counts acknowledged tenures that have not yet retired, seen only at the ports
  always_ff @(posedge clk) begin
    if (rst) outstanding_q <= '0;
    else if (abus_ack && !retire) outstanding_q <= outstanding_q + 1'b1;
    else if (retire && !abus_ack) outstanding_q <= outstanding_q - 1'b1;
  end

  // R1
  agnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(abus_gnt));
  // R1
  dgnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(dbus_gnt));
  // R3
  agnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|abus_gnt && !abus_ack) |=> $stable(abus_gnt));
  // R4
  ack_has_grant_chk: assert property (@(posedge clk) disable iff (rst) abus_ack |-> |abus_gnt);
  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    abus_ack |=> (!abus_ack && abus_gnt == '0));
  // R5
  depth_limit_chk: assert property (@(posedge clk) disable iff (rst)
    outstanding_q <= CW'(DEPTH));
  // R6
  dgnt_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(|dbus_gnt) |-> outstanding_q != '0);
  // R7
  dgnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|dbus_gnt && !retire) |=> $stable(dbus_gnt));
  // R8
  dgnt_drop_chk: assert property (@(posedge clk) disable iff (rst)
    retire |=> dbus_gnt == '0);
endmodule

bind split_bus_arbiter split_arb_chk #(.N(N_MASTERS), .DEPTH(PIPE_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .abus_req  (abus_req),
  .abus_gnt  (abus_gnt),
  .abus_ack  (abus_ack),
  .dbus_gnt  (dbus_gnt),
  .dbus_last (dbus_last)
);

// File: tb/split_bus_arbiter_bench.sv
`timescale 1ns/1ps
module split_bus_arbiter_bench;
  localparam int NM = 4;
  localparam int NV = 25;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NM-1:0] req = '0;
  logic [NM-1:0] last = '0;
  logic [NM-1:0] agnt, dgnt;
  logic          aack;
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  split_bus_arbiter #(.N_MASTERS(NM), .PIPE_DEPTH(2)) u_split_bus_arbiter (
    .clk (clk), .rst (rst), .abus_req (req), .abus_gnt (agnt),
    .abus_ack (aack), .dbus_gnt (dgnt), .dbus_last (last)
  );

  // {req, last, expected abus_gnt, expected abus_ack, expected dbus_gnt}
  localparam logic [16:0] VEC [NV] = '{
    {4'b0011, 4'b0000, 4'b0001, 1'b0, 4'b0000}, // R2 start at master 0
    {4'b0011, 4'b0000, 4'b0001, 1'b1, 4'b0000}, // R4 ack one cycle on
    {4'b0011, 4'b0000, 4'b0000, 1'b0, 4'b0001}, // R6 data grant to head
    {4'b0011, 4'b0000, 4'b0010, 1'b0, 4'b0001}, // R2 next master, R10 overlap
    {4'b0010, 4'b0000, 4'b0010, 1'b1, 4'b0001}, // R10 ack during data
    {4'b0100, 4'b0000, 4'b0000, 1'b0, 4'b0001}, // R3 request ignored in ack
    {4'b0100, 4'b0000, 4'b0100, 1'b0, 4'b0001},
    {4'b0100, 4'b0000, 4'b0100, 1'b0, 4'b0001}, // R5 queue full, no ack
    {4'b0100, 4'b0001, 4'b0100, 1'b0, 4'b0000}, // R8 retire, R5 still held
    {4'b0100, 4'b0000, 4'b0100, 1'b1, 4'b0010}, // R5 ack after slot frees, R6 order
    {4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0010},
    {4'b0000, 4'b0001, 4'b0000, 1'b0, 4'b0010}, // R7 foreign last ignored
    {4'b1000, 4'b0010, 4'b1000, 1'b0, 4'b0000}, // R8 drop on last
    {4'b1000, 4'b0000, 4'b1000, 1'b1, 4'b0100}, // R6 master 2 follows
    {4'b0000, 4'b0100, 4'b0000, 1'b0, 4'b0000},
    {4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b1000},
    {4'b0000, 4'b1000, 4'b0000, 1'b0, 4'b0000},
    {4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000},
    {4'b1001, 4'b0000, 4'b0001, 1'b0, 4'b0000}, // R2 wrap to master 0
    {4'b1001, 4'b0000, 4'b0001, 1'b1, 4'b0000},
    {4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0001},
    {4'b1001, 4'b0001, 4'b1000, 1'b0, 4'b0000}, // R2 master 3 after 0
    {4'b0000, 4'b0000, 4'b1000, 1'b1, 4'b0000},
    {4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b1000},
    {4'b0000, 4'b1000, 4'b0000, 1'b0, 4'b0000}
  };

  task automatic check(input string tag, input logic [3:0] ea, input logic ek,
                       input logic [3:0] ed);
    n_cmp++;
    if (agnt !== ea || aack !== ek || dgnt !== ed) begin
      n_bad++;
      $display("FAIL %s: got agnt=%b ack=%b dgnt=%b, expected agnt=%b ack=%b dgnt=%b",
               tag, agnt, aack, dgnt, ea, ek, ed);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic [3:0] l, input logic rs);
    @(negedge clk);
    req = r; last = l; rst = rs;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R9 reset state
    step(4'b0011, 4'b0000, 1'b1);
    step(4'b0011, 4'b0000, 1'b1);
    check("R9 reset outputs", 4'b0000, 1'b0, 4'b0000);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][16:13], VEC[v][12:9], 1'b0);
      check($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 R10 vector %0d", v),
            VEC[v][8:5], VEC[v][4], VEC[v][3:0]);
    end

    // R9 reset while an entry is queued
    step(4'b0001, 4'b0000, 1'b0);
    check("R2 grant master 0", 4'b0001, 1'b0, 4'b0000);
    step(4'b0001, 4'b0000, 1'b0);
    check("R4 ack before reset", 4'b0001, 1'b1, 4'b0000);
    step(4'b0000, 4'b0000, 1'b1);
    check("R9 reset clears grants", 4'b0000, 1'b0, 4'b0000);
    for (int k = 0; k < 4; k++) begin
      step(4'b0000, 4'b0000, 1'b0);
      check("R9 queue emptied", 4'b0000, 1'b0, 4'b0000);
    end
    // R2 pointer back at master 0 after reset
    step(4'b0011, 4'b0000, 1'b0);
    check("R2 R9 pointer reset", 4'b0001, 1'b0, 4'b0000);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got no finish, expected finish before timeout");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule